// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ninth-Bit Address Filtering

This block turns a serial input line into characters. It works from a sample tick that runs at sixteen times the bit rate. A character is a start bit, eight data bits sent least significant first, an optional ninth bit, and a stop bit. Each recovered character goes into a two-entry receive queue. The character at the head of the queue is shown on the read-data outputs, together with its ninth bit and its framing-error status. A one-cycle read strobe removes that head entry. The receive-interrupt output stays high while the queue holds anything.

Several stations can share one line. For that case, an address-filter mode can be turned on in 9-bit operation. It keeps only characters whose ninth bit is 1 and drops all others without any trace. The port-enable input holds the whole receiver in reset. The receive-enable input starts and stops reception. Clearing either of these is the only way to clear a sticky overrun flag. That flag is raised when a character arrives while the queue is full.

Top module: `serrx_core`

## Requirements
- R1: While `port_en_i` is 0, the block is held in reset. From the clock after it goes low, `irq_o`, `ovr_err_o`, `dat_o`, `bit9_o` and `frm_err_o` all read 0, and the queue is empty. Whatever the queue held is discarded.
- R2: A character starts with a falling edge on `rxd_i`. Each bit lasts 16 ticks. The value of a bit is the majority of three samples, taken at ticks 7, 8 and 9 of that bit. Data bits arrive least significant first, and data bit 0 appears on `dat_o[0]`.
- R3: If the start-bit majority vote reads high, the start is false. The receiver returns to idle and stores no character.
- R4: When `nine_bit_i` is 0, a character has 8 data bits and `bit9_o` reads 0. In this mode `addr_det_i` has no effect, so every character is stored.
- R5: When `nine_bit_i` is 1, a ninth bit is received after data bit 7. It appears on `bit9_o` along with its character. When `addr_det_i` is 0, every character is stored, whatever its ninth bit.
- R6: When `nine_bit_i` and `addr_det_i` are both 1, a character whose ninth bit is 0 is discarded. It leaves the queue, `irq_o` and `ovr_err_o` unchanged.
- R7: `frm_err_o` is 1 when the character at the head of the queue had its stop bit sampled low. Otherwise it is 0.
- R8: The queue holds 2 characters and returns them in arrival order. `irq_o` is high while the queue is non-empty. A `rd_i` pulse removes the head, and the outputs then show the next character's data, ninth bit and framing status.
- R9: If a character that would be stored completes while the queue is full, `ovr_err_o` is set and that character is lost. While `ovr_err_o` is 1, no new character is stored, even if the queue has space.
- R10: `ovr_err_o` stays set until `port_en_i` or `rx_en_i` is driven to 0. Reading the queue does not clear it.
- R11: While `rx_en_i` is 0, the receiver stays idle and stores no characters, but the queue keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Port enable; 0 holds the block in reset |
| rx_en_i | input | 1 | Receive enable |
| nine_bit_i | input | 1 | 1 selects 9-bit characters |
| addr_det_i | input | 1 | Address filter enable (9-bit mode only) |
| rxd_i | input | 1 | Serial input line, idle high |
| tick_i | input | 1 | Sample tick at 16 times the bit rate |
| rd_i | input | 1 | Read strobe; removes the queue head |
| dat_o | output | 8 | Data of the queue head |
| bit9_o | output | 1 | Ninth bit of the queue head |
| frm_err_o | output | 1 | Framing error of the queue head |
| ovr_err_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receive interrupt; high while the queue is non-empty |

## Verification
Characters are sent with alternating patterns, all zeros and all ones. These show whether the bit order is right and whether any bit position is stuck. The same ninth-bit values are sent with the address filter on and off, and in 8-bit mode. Comparing the results shows whether a character was dropped because of the filter or because of the mode. Further tests cover a short low glitch, a low stop bit, and filling the queue with the reader halted. These separate a false start from a real character, a framing error from a good character, and a full queue from an overrun. They also show that clearing the receive enable or the port enable is the only way to clear the overrun flag.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
   localparam int unsigned RX_DW  = 8;
   localparam int unsigned RX_OSR = 16;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad
      $error("serrx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ff <= '1;
      else if (clr) ff <= '1;
      else          ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/serrx_deser.sv
module serrx_deser
   import serrx_pkg::*;
#(
   parameter int DW  = RX_DW,
   parameter int OSR = RX_OSR
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        tick,
   input  logic        rxd,
   input  logic        nine,
   output logic        done,
   output logic [DW:0] word,
   output logic        ferr
);
   localparam int CW = $clog2(OSR);
   localparam int BW = $clog2(DW + 1);
   localparam logic [CW-1:0] PH_A   = CW'(OSR/2 - 1);
   localparam logic [CW-1:0] PH_B   = CW'(OSR/2);
   localparam logic [CW-1:0] PH_C   = CW'(OSR/2 + 1);
   localparam logic [CW-1:0] PH_END = CW'(OSR - 1);

   if (OSR < 8 || (1 << CW) != OSR) begin : g_bad_osr
      $error("serrx_deser: OSR must be a power of two, at least 8");
   end
   if (DW < 2) begin : g_bad_dw
      $error("serrx_deser: DW must be at least 2");
   end

   rx_state_e     st;
   logic [CW-1:0] cnt;
   logic [1:0]    vote;
   logic [BW-1:0] idx;
   logic [DW:0]   sh;
   logic          bitv;
   logic [BW-1:0] last_idx;

   assign bitv     = maj3(vote[0], vote[1], rxd);
   assign last_idx = nine ? BW'(DW) : BW'(DW - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_IDLE; cnt <= '0; vote <= '0; idx <= '0;
         sh <= '0; done <= 1'b0; ferr <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            st  <= RX_IDLE;
            cnt <= '0;
         end else if (tick) begin
            if (st == RX_IDLE) begin
               if (!rxd) begin
                  st  <= RX_START;
                  cnt <= CW'(1);
                  idx <= '0;
                  sh  <= '0;
               end
            end else begin
               cnt <= (cnt == PH_END) ? '0 : cnt + 1'b1;
               if (cnt == PH_A) vote[0] <= rxd;
               if (cnt == PH_B) vote[1] <= rxd;
               unique case (st)
                  RX_START: begin
                     if (cnt == PH_C && bitv) st <= RX_IDLE;
                     else if (cnt == PH_END)  st <= RX_DATA;
                  end
                  RX_DATA: begin
                     if (cnt == PH_C) sh[idx] <= bitv;
                     if (cnt == PH_END) begin
                        if (idx == last_idx) st <= RX_STOP;
                        else                 idx <= idx + 1'b1;
                     end
                  end
                  RX_STOP: begin
                     if (cnt == PH_C) begin
                        done <= 1'b1;
                        ferr <= ~bitv;
                        st   <= RX_IDLE;
                     end
                  end
                  default: st <= RX_IDLE;
               endcase
            end
         end
      end
   end

   assign word = sh;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_HALT_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !done); // R11
endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad
      $error("serrx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_pop;

   assign empty  = (level == '0);
   assign full   = (level == LW'(DEPTH));
   assign do_pop = pop & ~empty;
   assign dout   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; level <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; level <= '0;
      end else begin
         if (push)   wp <= wp + 1'b1;
         if (do_pop) rp <= rp + 1'b1;
         level <= level + LW'(push) - LW'(do_pop);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             mem[i] <= '0;
         else if (push && wp == AW'(i) && !clr)  mem[i] <= din;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R9
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push && !clr) |=> (level == $past(level) - 1'b1)); // R8
endmodule

// File: rtl/serrx_core.sv
module serrx_core
   import serrx_pkg::*;
#(
   parameter int DW      = RX_DW,
   parameter int OSR     = RX_OSR,
   parameter int DEPTH   = 2,
   parameter int SYNC_FF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          port_en_i,
   input  logic          rx_en_i,
   input  logic          nine_bit_i,
   input  logic          addr_det_i,
   input  logic          rxd_i,
   input  logic          tick_i,
   input  logic          rd_i,
   output logic [DW-1:0] dat_o,
   output logic          bit9_o,
   output logic          frm_err_o,
   output logic          ovr_err_o,
   output logic          irq_o
);
   localparam int EW = DW + 2;
   localparam int LW = $clog2(DEPTH + 1);

   logic          rxd_s, run, done, ferr, accept, push, ovr_q;
   logic [DW:0]   word;
   logic [EW-1:0] head;
   logic          empty, full;
   logic [LW-1:0] level;

   assign run = port_en_i & rx_en_i;

   serrx_sync #(.STAGES(SYNC_FF)) i_sync (
      .clk(clk), .rst_n(rst_n), .clr(~port_en_i), .d(rxd_i), .q(rxd_s)
   );

   serrx_deser #(.DW(DW), .OSR(OSR)) i_deser (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_i), .rxd(rxd_s),
      .nine(nine_bit_i), .done(done), .word(word), .ferr(ferr)
   );

   assign accept = done & (~(nine_bit_i & addr_det_i) | word[DW]);
   assign push   = accept & ~full & ~ovr_q & port_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ovr_q <= 1'b0;
      else if (!run)           ovr_q <= 1'b0;
      else if (accept && full) ovr_q <= 1'b1;
   end

   serrx_fifo #(.W(EW), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .clr(~port_en_i), .push(push),
      .din({ferr, word}), .pop(rd_i), .dout(head),
      .empty(empty), .full(full), .level(level)
   );

   assign dat_o     = empty ? '0 : head[DW-1:0];
   assign bit9_o    = empty ? 1'b0 : head[DW];
   assign frm_err_o = empty ? 1'b0 : head[DW+1];
   assign ovr_err_o = ovr_q;
   assign irq_o     = ~empty;

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en_i |=> (!irq_o && !ovr_err_o && dat_o == '0)); // R1
   AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && nine_bit_i && addr_det_i && !word[DW] && !rd_i && run)
      |=> (level == $past(level) && ovr_err_o == $past(ovr_err_o))); // R6
   AST_NO_LOAD_IN_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && port_en_i && !rd_i) |=> (level <= $past(level))); // R9
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && run) |=> ovr_err_o); // R10
endmodule

// File: tb/test_serrx_core.sv
module test_serrx_core;
   localparam int CLK_P = 10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       port_en = 1'b0, rx_en = 1'b0, nine = 1'b0, addr = 1'b0;
   logic       rxd = 1'b1, tick = 1'b0, rd = 1'b0;
   logic [7:0] dat;
   logic       b9, ferr, ovr, irq;

   int nvec = 0, nbad = 0;
   bit mon_en = 1'b0;
   logic [9:0] expq[$];

   always #(CLK_P/2) clk = ~clk;

   serrx_core i_serrx_core (
      .clk(clk), .rst_n(rst_n), .port_en_i(port_en), .rx_en_i(rx_en),
      .nine_bit_i(nine), .addr_det_i(addr), .rxd_i(rxd), .tick_i(tick),
      .rd_i(rd), .dat_o(dat), .bit9_o(b9), .frm_err_o(ferr),
      .ovr_err_o(ovr), .irq_o(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp_v);
      end
   endtask

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (tick !== 1'b1) @(posedge clk);
      end
      @(negedge clk);
   endtask

   // drive one frame; push the expected head entry when it should be stored
   task automatic send(input logic [8:0] ch, input bit stop_hi, input bit acc);
      if (acc) expq.push_back({~stop_hi, nine ? ch[8] : 1'b0, ch[7:0]});
      rxd = 1'b0; wait_ticks(16);
      for (int i = 0; i < 8; i++) begin rxd = ch[i]; wait_ticks(16); end
      if (nine) begin rxd = ch[8]; wait_ticks(16); end
      rxd = stop_hi; wait_ticks(16);
      rxd = 1'b1; wait_ticks(16);
   endtask

   // monitor: pops expected items and compares with the queue head
   initial begin
      forever begin
         @(negedge clk);
         if (mon_en && irq === 1'b1) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R8 unexpected character", {ferr, b9, dat}, 0);
            end else begin
               logic [9:0] e;
               e = expq.pop_front();
               chk({ferr, b9, dat} === e, "R2/R5/R7/R8 head entry", {ferr, b9, dat}, e);
            end
            rd = 1'b1;
            @(negedge clk);
            rd = 1'b0;
         end
      end
   end

   task automatic drain;
      for (int i = 0; i < 200 && (expq.size() != 0 || irq); i++) @(negedge clk);
      chk(expq.size() == 0, "R8 all expected characters seen", expq.size(), 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      nbad++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq == 0 && ovr == 0 && dat == 0 && ferr == 0 && b9 == 0, "R1 reset state",
          {irq, ovr, ferr, b9, dat}, 0);
      port_en = 1'b1; rx_en = 1'b1; mon_en = 1'b1;
      wait_ticks(20);

      // R2 R4: 8-bit patterns
      send(9'h0A5, 1'b1, 1'b1); send(9'h03C, 1'b1, 1'b1);
      send(9'h000, 1'b1, 1'b1); send(9'h0FF, 1'b1, 1'b1);
      // R4: address filter has no effect in 8-bit mode
      addr = 1'b1;
      send(9'h012, 1'b1, 1'b1);
      drain();
      addr = 1'b0;

      // R5: ninth bit passed through, filter off
      nine = 1'b1;
      send(9'h155, 1'b1, 1'b1); send(9'h0AA, 1'b1, 1'b1);
      drain();

      // R6: filter on, ninth bit 0 dropped
      addr = 1'b1; mon_en = 1'b0;
      send(9'h011, 1'b1, 1'b0);
      chk(irq == 0 && ovr == 0, "R6 dropped character", {irq, ovr}, 0);
      mon_en = 1'b1;
      send(9'h122, 1'b1, 1'b1);
      drain();
      addr = 1'b0; nine = 1'b0;

      // R7: framing error on low stop bit
      send(9'h05A, 1'b0, 1'b1); send(9'h0C3, 1'b1, 1'b1);
      drain();

      // R3: short glitch is a false start
      mon_en = 1'b0;
      rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(32);
      chk(irq == 0, "R3 false start stores nothing", irq, 0);
      mon_en = 1'b1;
      send(9'h081, 1'b1, 1'b1);
      drain();

      // R8: two entries held, order and status update on read
      mon_en = 1'b0;
      send(9'h0E7, 1'b0, 1'b1); send(9'h018, 1'b1, 1'b1);
      chk(irq == 1 && dat == 8'hE7 && ferr == 1, "R8 head after two", {irq, ferr, dat}, 'h3E7);
      mon_en = 1'b1;
      drain();

      // R9: overrun on third character
      mon_en = 1'b0;
      send(9'h031, 1'b1, 1'b1); send(9'h032, 1'b1, 1'b1); send(9'h033, 1'b1, 1'b0);
      chk(ovr == 1, "R9 overrun set", ovr, 1);
      mon_en = 1'b1;
      drain();
      chk(ovr == 1, "R10 read does not clear overrun", ovr, 1);
      mon_en = 1'b0;
      send(9'h034, 1'b1, 1'b0);
      chk(irq == 0, "R9 no load while overrun", irq, 0);
      rx_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(ovr == 0, "R10 receive enable clears overrun", ovr, 1'b0);

      // R11: receiver off stores nothing
      send(9'h0B6, 1'b1, 1'b0);
      chk(irq == 0, "R11 disabled receiver", irq, 0);
      rx_en = 1'b1; mon_en = 1'b1;
      wait_ticks(4);
      send(9'h06B, 1'b1, 1'b1);
      drain();

      // R1: port disable flushes queue and flags
      mon_en = 1'b0;
      send(9'h0F0, 1'b0, 1'b1);
      chk(irq == 1 && ferr == 1, "R1 queue loaded before disable", {irq, ferr}, 3);
      port_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(irq == 0 && dat == 0 && ferr == 0 && b9 == 0 && ovr == 0, "R1 disabled outputs",
          {irq, ovr, ferr, b9, dat}, 0);
      void'(expq.pop_front());
      port_en = 1'b1;
      repeat (4) @(negedge clk);
      chk(irq == 0, "R1 queue empty after re-enable", irq, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule